// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter built from identical slices of `WIDTH` bits each. `STAGES` slices are chained into one counter of `STAGES*WIDTH` bits. All state bits of all slices change together on the rising edge of a single clock. At each edge the counter does one of three things. It loads a parallel data word when the active-low load input is low. It counts up or down when both active-low count enables are low. Otherwise it holds its value. Load wins over counting when both are requested at the same edge. The direction input selects up (high) or down (low). The count wraps at both ends.

Each slice drives an active-low terminal-count carry. The carry is low only while the slice's feed-forward enable is low and the slice sits at its terminal value: all ones when counting up, zero when counting down. Inside the chain, this carry drives the feed-forward enable of the next slice, so no extra gate is needed between slices. The hold enable is shared by every slice. The carry of the last slice is brought out so that several chains can be joined in turn. An active-low asynchronous reset clears the whole count to zero. Apart from that reset, every control input is looked at only at the rising edge.

Top module: `updn_cascade`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, whatever the clock does.
- R2: When `load_n` is low at a rising edge, `q` takes the value of `din` at that edge.
- R3: When `load_n` is high and either `en_p_n` or `en_t_n` is high at a rising edge, `q` keeps its value.
- R4: When `load_n`, `en_p_n` and `en_t_n` are low... rather, when `load_n` is high, both enables are low and `up` is 1 at a rising edge, `q` increases by one, wrapping from all ones to zero.
- R5: When `load_n` is high, both enables are low and `up` is 0 at a rising edge, `q` decreases by one, wrapping from zero to all ones.
- R6: `carry_n` is 1 whenever `en_t_n` is 1.
- R7: `carry_n` is 0 exactly when `en_t_n` is 0 and either `up` is 1 with `q` all ones, or `up` is 0 with `q` all zeros. It follows `q`, `en_t_n` and `up` with no clock delay.
- R8: The chained slices behave as a single `STAGES*WIDTH`-bit counter. A carry out of one slice reaches the next slice at the same edge, and no slice advances while `en_p_n` is high.
- R9: Pulses on `load_n`, `up` or the enables that begin and end between two rising edges leave `q` unchanged.
- R10: When a load and a count are both requested at the same edge, the load wins, and `q` equals `din` rather than `din` plus or minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every slice |
| rst_n | input | 1 | Asynchronous active-low clear to zero |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p_n | input | 1 | Active-low count enable shared by all slices |
| en_t_n | input | 1 | Active-low count enable of the lowest slice, fed forward into its carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | STAGES*WIDTH | Parallel load data |
| q | output | STAGES*WIDTH | Counter value |
| carry_n | output | 1 | Active-low terminal-count carry of the top slice |

## Verification
A load and a count can be requested at the same rising edge. The bench provokes this by holding both enables low with a direction set while `load_n` is low. It judges the result by requiring `q` to equal `din` exactly, with no step applied. The other overlap is between the hold enable and a live carry. With `en_t_n` low and the low slice at its terminal value, `carry_n` falls even though `en_p_n` is high. The bench checks that the upper slices still do not advance, by comparing the full chained value against an independent wide reference counter.

// File: rtl/updn_pkg.sv
package updn_pkg;

   // Action chosen for a slice at the next rising edge.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_INC  = 2'd2,
      ACT_DEC  = 2'd3
   } updn_act_e;

   // Sampled control word shared by every slice.
   typedef struct packed {
      logic load_n;
      logic en_p_n;
      logic en_t_n;
      logic up;
   } updn_ctrl_t;

   // Load has priority, then counting, then hold.
   function automatic updn_act_e pick_action(input updn_ctrl_t c);
      if (!c.load_n)
         return ACT_LOAD;
      else if (!c.en_p_n && !c.en_t_n)
         return c.up ? ACT_INC : ACT_DEC;
      else
         return ACT_HOLD;
   endfunction

endpackage

// File: rtl/updn_step.sv
module updn_step
   import updn_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  updn_ctrl_t       ctrl,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   updn_act_e act;

   always_comb begin
      act = pick_action(ctrl);
      unique case (act)
         ACT_LOAD: nxt = din;
         ACT_INC:  nxt = cur + ONE;
         ACT_DEC:  nxt = cur - ONE;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/updn_term.sv
module updn_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_t_n,
   input  logic             up,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BOT_VAL = '0;

   logic at_top;
   logic at_bot;

   assign at_top  = (cur == TOP_VAL);
   assign at_bot  = (cur == BOT_VAL);
   assign carry_n = ~(~en_t_n & (up ? at_top : at_bot));

endmodule

// File: rtl/updn_slice.sv
module updn_slice
   import updn_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  updn_ctrl_t       ctrl,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_n
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] cnt;
   logic [WIDTH-1:0] cnt_nxt;

   updn_step #(.WIDTH(WIDTH)) u_step (
      .ctrl (ctrl),
      .cur  (cnt),
      .din  (din),
      .nxt  (cnt_nxt)
   );

   updn_term #(.WIDTH(WIDTH)) u_term (
      .cur     (cnt),
      .en_t_n  (ctrl.en_t_n),
      .up      (ctrl.up),
      .carry_n (carry_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= cnt_nxt;
   end

   assign q = cnt;

   // R2 / R10: load lands the data regardless of the enables
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.load_n |=> q == $past(din))
      else $error("slice load not taken");

   // R3: hold when either enable is high
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.load_n && (ctrl.en_p_n || ctrl.en_t_n)) |=> $stable(q))
      else $error("slice moved while disabled");

   // R4: increment with wrap
   p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.load_n && !ctrl.en_p_n && !ctrl.en_t_n && ctrl.up)
         |=> q == $past(q) + ONE)
      else $error("slice increment wrong");

   // R5: decrement with wrap
   p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.load_n && !ctrl.en_p_n && !ctrl.en_t_n && !ctrl.up)
         |=> q == $past(q) - ONE)
      else $error("slice decrement wrong");

   // R6: carry is blocked by the feed-forward enable
   p_carry_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en_t_n |-> carry_n)
      else $error("carry active while feed-forward enable high");

endmodule

// File: rtl/updn_cascade.sv
module updn_cascade
   import updn_pkg::*;
#(
   parameter int STAGES = 3,
   parameter int WIDTH  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_n,
   input  logic                      en_p_n,
   input  logic                      en_t_n,
   input  logic                      up,
   input  logic [STAGES*WIDTH-1:0]   din,
   output logic [STAGES*WIDTH-1:0]   q,
   output logic                      carry_n
);

   localparam int TOTAL = STAGES * WIDTH;
   localparam logic [TOTAL-1:0] ONE_W = TOTAL'(1);
   localparam logic [TOTAL-1:0] ALL1  = {TOTAL{1'b1}};

   if (STAGES < 1) begin : g_bad_stages
      $error("updn_cascade: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("updn_cascade: WIDTH must be at least 1");
   end

   // t_chain[k] is the feed-forward enable of slice k; t_chain[k+1] is its carry.
   logic [STAGES:0] t_chain;
   assign t_chain[0] = en_t_n;

   for (genvar k = 0; k < STAGES; k++) begin : g_slice
      updn_ctrl_t ctrl_k;

      if (k == 0) begin : g_head
         assign ctrl_k = '{load_n: load_n, en_p_n: en_p_n,
                           en_t_n: en_t_n, up: up};
      end else begin : g_link
         assign ctrl_k = '{load_n: load_n, en_p_n: en_p_n,
                           en_t_n: t_chain[k], up: up};
      end

      updn_slice #(.WIDTH(WIDTH)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl    (ctrl_k),
         .din     (din[k*WIDTH +: WIDTH]),
         .q       (q[k*WIDTH +: WIDTH]),
         .carry_n (t_chain[k+1])
      );
   end

   assign carry_n = t_chain[STAGES];

   // R8: whole chain increments as one wide counter
   p_chain_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !en_p_n && !en_t_n && up) |=> q == $past(q) + ONE_W)
      else $error("chain increment wrong");

   // R8: whole chain decrements as one wide counter
   p_chain_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !en_p_n && !en_t_n && !up) |=> q == $past(q) - ONE_W)
      else $error("chain decrement wrong");

   // R8: shared hold enable freezes every slice
   p_chain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_p_n) |=> $stable(q))
      else $error("chain moved with hold enable high");

   // R7: terminal count going up drives the carry low
   p_term_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_t_n && up && q == ALL1) |-> !carry_n)
      else $error("missing up terminal carry");

   // R7: terminal count going down drives the carry low
   p_term_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_t_n && !up && q == '0) |-> !carry_n)
      else $error("missing down terminal carry");

endmodule

// File: tb/updn_cascade_bench.sv
module updn_cascade_bench;

   localparam int CLK_PERIOD = 10;
   localparam int STAGES = 3;
   localparam int WIDTH  = 4;
   localparam int NB     = STAGES * WIDTH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_n = 1'b1;
   logic          en_p_n = 1'b1;
   logic          en_t_n = 1'b1;
   logic          up = 1'b1;
   logic [NB-1:0] din = '0;
   logic [NB-1:0] q;
   logic          carry_n;

   logic [NB-1:0] ref_q = '0;
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_cascade #(.STAGES(STAGES), .WIDTH(WIDTH)) u_updn_cascade (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p_n(en_p_n),
      .en_t_n(en_t_n), .up(up), .din(din), .q(q), .carry_n(carry_n)
   );

   function automatic logic exp_carry();
      logic term;
      term = up ? (ref_q == {NB{1'b1}}) : (ref_q == '0);
      return ~(~en_t_n & term);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act,
                      input logic [NB-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_q(input string tag);
      chk(q == ref_q, tag, q, ref_q);
   endtask

   task automatic chk_c(input string tag);
      logic e;
      e = exp_carry();
      chk(carry_n == e, tag, NB'(carry_n), NB'(e));
   endtask

   task automatic drive(input logic l, input logic p, input logic t,
                        input logic u, input logic [NB-1:0] d);
      @(negedge clk);
      load_n = l; en_p_n = p; en_t_n = t; up = u; din = d;
   endtask

   task automatic tick();
      @(posedge clk);
      if (!load_n) ref_q = din;
      else if (!en_p_n && !en_t_n) ref_q = up ? ref_q + 1'b1 : ref_q - 1'b1;
      #1;
   endtask

   task automatic t_reset();
      chk_q("R1 reset value");
      chk_c("R6 carry under reset with en_t high");
      repeat (2) @(posedge clk);
      #1 chk_q("R1 reset holds across edges");
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic t_load();
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hA5C); tick(); chk_q("R2 load A5C");
      drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h3B7); tick();
      chk_q("R10 load beats count up");
      drive(1'b0, 1'b0, 1'b0, 1'b0, 12'h800); tick();
      chk_q("R10 load beats count down");
   endtask

   task automatic t_up_wrap();
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFD); tick();
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0);
      for (int i = 0; i < 5; i++) begin
         chk_c("R7 carry while counting up");
         tick(); chk_q("R4 count up through wrap");
      end
   endtask

   task automatic t_down_wrap();
      drive(1'b0, 1'b1, 1'b1, 1'b0, 12'h002); tick();
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
      for (int i = 0; i < 5; i++) begin
         chk_c("R7 carry while counting down");
         tick(); chk_q("R5 count down through wrap");
      end
   endtask

   task automatic t_cascade();
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h0EE); tick();
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0);
      for (int i = 0; i < 20; i++) begin tick(); chk_q("R8 chained up across slices"); end
      drive(1'b0, 1'b1, 1'b1, 1'b0, 12'h101); tick();
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
      for (int i = 0; i < 20; i++) begin tick(); chk_q("R8 chained down across slices"); end
   endtask

   task automatic t_hold();
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF); tick();
      drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
      #1 chk_c("R7 low slices terminal, top not");
      tick(); chk_q("R8 hold enable freezes upper slices");
      drive(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFF); tick();
      drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
      #1 chk_c("R7 full terminal up with hold enable high");
      chk(carry_n == 1'b0, "R7 carry low at FFF", NB'(carry_n), '0);
      tick(); chk_q("R3 hold via en_p_n");
      drive(1'b1, 1'b0, 1'b1, 1'b1, '0);
      #1 chk_c("R6 carry blocked by en_t_n");
      tick(); chk_q("R3 hold via en_t_n");
      drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
      #1 chk_c("R7 direction down at FFF gives no carry");
   endtask

   task automatic t_between();
      drive(1'b1, 1'b1, 1'b1, 1'b1, '0); tick();
      #1 load_n = 1'b0; en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b0; din = 12'h123;
      #2 load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1;
      tick(); chk_q("R9 pulses between edges ignored");
   endtask

   task automatic t_async_reset();
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0); tick(); tick();
      #1 rst_n = 1'b0; ref_q = '0;
      #1 chk_q("R1 asynchronous clear mid count");
      @(negedge clk) rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #2;
      t_reset();
      t_load();
      t_up_wrap();
      t_down_wrap();
      t_cascade();
      t_hold();
      t_between();
      t_async_reset();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule